// File: doc/BRIEF.md
# Set-Associative LRU Tag-Store Simulator

This block models only the tag side of a set-associative cache. It stores no data. Each request carries a byte address and an access width of 1 to 8 bytes. The block decides whether the reference hits or misses, updates the per-set recency order, and keeps a 64-bit count of misses. The cache is write-allocate, so every miss installs its tag whatever the access type. The geometry (total bytes, line bytes, ways) is set by power-of-two parameters. The set count is derived from them.

Every set stores its tags as an ordered list, from most recently used (way 0) to least recently used (the last way). A hit moves the tag to the front, and a miss pushes the oldest tag out. A reference that runs past the end of a line examines two neighbouring sets, one per cycle, but yields a single result. A reference that would span three or more lines has no defined result. It raises a sticky error flag instead.

Top module: `cache_tag_sim`

## Requirements
- R1: After reset, `miss_count` is 0, `err_flag` is 0, `req_ready` is 1 and `rsp_valid` is 0. Every stored tag is zero and there are no valid bits, so a reference whose tag field is zero hits straight away.
- R2: Address decoding:
  - The low log2(LINE_BYTES) bits are the line offset.
  - The next log2(SETS) bits select the set, by plain bit selection.
  - The remaining upper bits form the tag.
  - SETS = CACHE_BYTES / LINE_BYTES / WAYS.
- R3: A reference that stays inside one line is accepted while `req_ready` is high. `rsp_valid` pulses for exactly one cycle after the accepting clock edge, and `req_ready` stays high.
- R4: A hit at way i > 0 places the tag in way 0 and moves ways 0..i-1 down by one. A hit at way 0 leaves the order unchanged.
- R5: A miss installs the tag in way 0, moves every way down by one and discards the least recently used tag.
- R6: A reference whose last byte falls in the next line takes two cycles:
  - It looks up the first set and then the following set. The tag taken from the start address is used in both lookups.
  - `req_ready` is low for the one cycle in between.
  - `rsp_valid` pulses one cycle after the second edge.
  - `rsp_miss` is 0 only if both lines hit. Both lines are allocated.
- R7: `miss_count` rises by exactly 1 in the cycle a response with `rsp_miss`=1 is presented, and is unchanged otherwise.
- R8: The set that follows the last set is set 0. A reference that crosses from the top set therefore continues in set 0.
- R9: A reference whose last byte lies two or more lines past its first line sets `err_flag`, which stays at 1 until reset. No response is produced, and later requests are still served.
- R10: With WAYS = 1 the block behaves as direct-mapped: every new tag replaces the single entry of its set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | 4 | Access width in bytes, 1..8 |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_miss | output | 1 | 1 = miss, 0 = hit, valid with `rsp_valid` |
| miss_count | output | 64 | Running miss total |
| err_flag | output | 1 | Sticky flag for a reference spanning more than two lines |

## Verification
A wrong recency order stays hidden until the set is filled beyond its way count. It then shows up as a hit where a miss was due, or the reverse, on the first reference to the tag that should have been evicted. Short conflict sequences within one set expose it within a few requests.

A wrong second-set index or tag on a line-crossing reference appears when the next line is looked up directly. That lookup returns the opposite result in the very next request. Counter or handshake faults show at once on `miss_count` and `req_ready`, in the cycle of the response.

// File: rtl/cache_sim_pkg.sv
package cache_sim_pkg;

    localparam int SZ_W  = 4;
    localparam int CNT_W = 64;

    typedef enum logic {
        ST_IDLE,
        ST_SECOND
    } phase_e;

    typedef struct packed {
        logic one_line;
        logic two_lines;
        logic too_wide;
    } span_t;

    // lines_past: how many line boundaries lie between first and last byte
    function automatic span_t classify_span(input logic [SZ_W-1:0] lines_past);
        span_t s;
        s.one_line  = (lines_past == '0);
        s.two_lines = (lines_past == SZ_W'(1));
        s.too_wide  = (lines_past > SZ_W'(1));
        return s;
    endfunction

endpackage

// File: rtl/cs_way_match.sv
module cs_way_match #(
    parameter int TAG_W = 8,
    parameter int WAYS  = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] row,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] eq;

    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_cmp
            assign eq[w] = (row[w] == tag);
        end
    endgenerate

    // lowest matching way wins
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(i);
            end
        end
    end
endmodule

// File: rtl/cs_lru_update.sv
module cs_lru_update #(
    parameter int TAG_W = 8,
    parameter int WAYS  = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] row,
    input  logic [TAG_W-1:0]           tag,
    input  logic                       hit,
    input  logic [WAY_W-1:0]           hit_way,
    output logic [WAYS-1:0][TAG_W-1:0] new_row
);
    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_way
            if (w == 0) begin : g_mru
                assign new_row[0] = tag;
            end else begin : g_rest
                // shift down every way at or above the hit position, or all on a miss
                assign new_row[w] = (!hit || (WAY_W'(w) <= hit_way)) ? row[w-1] : row[w];
            end
        end
    endgenerate
endmodule

// File: rtl/cs_miss_counter.sv
module cs_miss_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= count + W'(1);
    end
endmodule

// File: rtl/cache_tag_sim.sv
module cache_tag_sim
    import cache_sim_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CACHE_BYTES = 128,
    parameter int LINE_BYTES  = 4,
    parameter int WAYS        = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size,
    output logic              rsp_valid,
    output logic              rsp_miss,
    output logic [CNT_W-1:0]  miss_count,
    output logic              err_flag
);
    localparam int SETS  = CACHE_BYTES / LINE_BYTES / WAYS;
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFS_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int END_W = OFS_W + SZ_W;

    typedef logic [WAYS-1:0][TAG_W-1:0] set_row_t;

    set_row_t   tag_mem [SETS];
    phase_e     phase;

    // decoded request
    logic [IDX_W-1:0] in_set;
    logic [TAG_W-1:0] in_tag;
    logic [END_W-1:0] end_ofs;
    logic [SZ_W-1:0]  lines_past;
    span_t            span;

    assign in_set     = req_addr[OFS_W +: IDX_W];
    assign in_tag     = req_addr[ADDR_W-1 -: TAG_W];
    assign end_ofs    = END_W'(req_addr[OFS_W-1:0]) + END_W'(req_size) - END_W'(1);
    assign lines_past = SZ_W'(end_ofs >> OFS_W);
    assign span       = classify_span(lines_past);

    // pending second half of a line-crossing reference
    logic [IDX_W-1:0] p_set;
    logic [TAG_W-1:0] p_tag;
    logic             p_miss;

    logic accept;
    assign req_ready = (phase == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // shared lookup path
    logic [IDX_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    set_row_t         lk_row;
    set_row_t         upd_row;
    logic             lk_hit;
    logic [WAY_W-1:0] lk_way;
    logic             do_update;

    assign lk_set    = (phase == ST_SECOND) ? p_set : in_set;
    assign lk_tag    = (phase == ST_SECOND) ? p_tag : in_tag;
    assign lk_row    = tag_mem[lk_set];
    assign do_update = (phase == ST_SECOND) || (accept && !span.too_wide);

    cs_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
        .row     (lk_row),
        .tag     (lk_tag),
        .hit     (lk_hit),
        .hit_way (lk_way)
    );

    cs_lru_update #(.TAG_W(TAG_W), .WAYS(WAYS)) u_lru (
        .row     (lk_row),
        .tag     (lk_tag),
        .hit     (lk_hit),
        .hit_way (lk_way),
        .new_row (upd_row)
    );

    // result produced this cycle
    logic fin_valid;
    logic fin_miss;

    always_comb begin
        fin_valid = 1'b0;
        fin_miss  = 1'b0;
        if (phase == ST_SECOND) begin
            fin_valid = 1'b1;
            fin_miss  = p_miss || !lk_hit;
        end else if (accept && span.one_line) begin
            fin_valid = 1'b1;
            fin_miss  = !lk_hit;
        end
    end

    cs_miss_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (fin_valid && fin_miss),
        .count (miss_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) tag_mem[s] <= '0;
        end else if (do_update) begin
            tag_mem[lk_set] <= upd_row;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_IDLE;
            p_set     <= '0;
            p_tag     <= '0;
            p_miss    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_miss  <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            rsp_valid <= fin_valid;
            if (fin_valid) rsp_miss <= fin_miss;
            case (phase)
                ST_IDLE: begin
                    if (accept && span.two_lines) begin
                        phase  <= ST_SECOND;
                        p_set  <= in_set + IDX_W'(1);
                        p_tag  <= in_tag;
                        p_miss <= !lk_hit;
                    end
                    if (accept && span.too_wide) err_flag <= 1'b1;
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cache_tag_sim_chk.sv
module cache_tag_sim_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_miss,
    input logic [63:0] miss_count,
    input logic        err_flag
);
    AST_CNT_STEP_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_miss) |-> (miss_count == $past(miss_count) + 64'd1)); // R7

    AST_CNT_STILL: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && rsp_miss) |-> (miss_count == $past(miss_count))); // R7

    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> (req_ready && rsp_valid)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag); // R9

    AST_ERR_NO_RSP: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> !rsp_valid); // R9
endmodule

bind cache_tag_sim cache_tag_sim_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_miss   (rsp_miss),
    .miss_count (miss_count),
    .err_flag   (err_flag)
);

// File: tb/sim_cache_tag_sim.sv
module sim_cache_tag_sim;
    // u0: 128 B, 4 B lines, 2 ways -> 16 sets, tag = addr >> 6
    // u1: 128 B, 4 B lines, 1 way  -> 32 sets, tag = addr >> 7
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        v   = 1'b0;
    logic [31:0] addr = '0;
    logic [3:0]  size = 4'd1;

    logic        rdy0, rv0, rm0, err0;
    logic [63:0] cnt0;
    logic        rdy1, rv1, rm1, err1;
    logic [63:0] cnt1;

    int n_run = 0;
    int n_fail = 0;
    longint exp_cnt = 0;

    always #4 clk = ~clk;

    cache_tag_sim u0 (
        .clk(clk), .rst(rst), .req_valid(v), .req_ready(rdy0), .req_addr(addr),
        .req_size(size), .rsp_valid(rv0), .rsp_miss(rm0), .miss_count(cnt0), .err_flag(err0)
    );

    cache_tag_sim #(.WAYS(1)) u1 (
        .clk(clk), .rst(rst), .req_valid(v), .req_ready(rdy1), .req_addr(addr),
        .req_size(size), .rsp_valid(rv1), .rsp_miss(rm1), .miss_count(cnt1), .err_flag(err1)
    );

    function automatic logic [31:0] ad(input int t, input int s, input int o);
        return 32'(t * 64 + s * 4 + o);
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    bit got, miss, dm_miss, rdy_mid;
    int lat;

    task automatic send(input logic [31:0] a, input logic [3:0] s);
        @(negedge clk);
        v = 1'b1; addr = a; size = s;
        @(posedge clk);
        @(negedge clk);
        v = 1'b0;
        got = 0; miss = 0; dm_miss = 0; lat = 0;
        rdy_mid = rdy0;
        for (int i = 1; i <= 3; i++) begin
            if (!got && rv0) begin
                got = 1; miss = rm0; dm_miss = rm1; lat = i;
            end
            if (i < 3) @(negedge clk);
        end
    endtask

    // request with expected outcome on u0
    task automatic ref_chk(input string req, input logic [31:0] a, input logic [3:0] s,
                           input bit exp_miss, input int exp_lat);
        send(a, s);
        if (exp_miss) exp_cnt++;
        chk(req, "response seen", longint'(got), 1);
        chk(req, "miss flag", longint'(miss), longint'(exp_miss));
        chk(req, "latency", longint'(lat), longint'(exp_lat));
        chk(req, "miss_count", longint'(cnt0), exp_cnt);
    endtask

    task automatic t_reset;
        chk("R1", "miss_count", longint'(cnt0), 0);
        chk("R1", "err_flag", longint'(err0), 0);
        chk("R1", "ready", longint'(rdy0), 1);
        chk("R1", "rsp_valid", longint'(rv0), 0);
        ref_chk("R1", ad(0, 7, 0), 4'd1, 0, 1);
    endtask

    task automatic t_miss_hit;
        ref_chk("R2", ad(1, 2, 1), 4'd2, 1, 1);
        chk("R3", "ready kept high", longint'(rdy_mid), 1);
        ref_chk("R2", ad(1, 2, 3), 4'd1, 0, 1);
        ref_chk("R2", ad(1, 3, 0), 4'd1, 1, 1);
        ref_chk("R3", ad(1, 2, 0), 4'd4, 0, 1);
    endtask

    task automatic t_lru;
        ref_chk("R5", ad(1, 4, 0), 4'd1, 1, 1);
        ref_chk("R5", ad(2, 4, 0), 4'd1, 1, 1);
        ref_chk("R4", ad(1, 4, 0), 4'd1, 0, 1);
        ref_chk("R5", ad(3, 4, 0), 4'd1, 1, 1);
        ref_chk("R4", ad(1, 4, 0), 4'd1, 0, 1);
        ref_chk("R5", ad(2, 4, 0), 4'd1, 1, 1);
        ref_chk("R5", ad(3, 4, 0), 4'd1, 1, 1);
        ref_chk("R4", ad(2, 4, 0), 4'd1, 0, 1);
    endtask

    task automatic t_straddle;
        ref_chk("R6", ad(3, 5, 0), 4'd4, 1, 1);
        ref_chk("R6", ad(3, 6, 0), 4'd4, 1, 1);
        ref_chk("R6", ad(3, 5, 2), 4'd4, 0, 2);
        chk("R6", "ready low mid", longint'(rdy_mid), 0);
        ref_chk("R6", ad(4, 8, 3), 4'd2, 1, 2);
        ref_chk("R6", ad(4, 8, 3), 4'd2, 0, 2);
        ref_chk("R6", ad(6, 10, 0), 4'd1, 1, 1);
        ref_chk("R6", ad(6, 10, 1), 4'd4, 1, 2);
        ref_chk("R6", ad(6, 11, 0), 4'd1, 0, 1);
    endtask

    task automatic t_wrap;
        ref_chk("R8", ad(2, 15, 3), 4'd2, 1, 2);
        ref_chk("R8", ad(2, 0, 0), 4'd1, 0, 1);
        ref_chk("R8", ad(3, 0, 0), 4'd1, 1, 1);
    endtask

    task automatic t_direct;
        // u1 set 0, tags 0x50 / 0x51; u0 set 0, tags 0xA0 / 0xA2
        ref_chk("R10", 32'h2800, 4'd1, 1, 1);
        chk("R10", "dm miss X", longint'(dm_miss), 1);
        ref_chk("R10", 32'h2880, 4'd1, 1, 1);
        chk("R10", "dm miss Y", longint'(dm_miss), 1);
        ref_chk("R10", 32'h2800, 4'd1, 0, 1);
        chk("R10", "dm X evicted", longint'(dm_miss), 1);
        ref_chk("R10", 32'h2800, 4'd1, 0, 1);
        chk("R10", "dm X hit", longint'(dm_miss), 0);
    endtask

    task automatic t_error;
        send(ad(5, 4, 1), 4'd8);
        chk("R9", "no response", longint'(got), 0);
        chk("R9", "err_flag set", longint'(err0), 1);
        chk("R9", "miss_count", longint'(cnt0), exp_cnt);
        ref_chk("R9", ad(5, 4, 0), 4'd1, 1, 1);
        chk("R9", "err_flag held", longint'(err0), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_miss_hit;
        t_lru;
        t_straddle;
        t_wrap;
        t_direct;
        t_error;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule